// File: doc/BRIEF.md
# Grouped interrupt status and mask

This block gathers single-cycle event pulses from a set of serial-channel sources and turns them into one level-sensitive interrupt request for an external interrupt controller. Each source owns one sticky status bit and one enable bit. A status bit is set only by its source pulse and is cleared only by software writing a zero into that bit position. Writing a one leaves the bit alone, so a handler can clear just the source it serviced without disturbing the others in the group.

Status bits are captured whether or not the matching enable bit is set, so software can poll masked sources. The enable bits act only on the combined output, which is registered and stays high while any enabled status bit is set. Software reaches both registers through a synchronous word-wide read/write port with byte-lane enables. Reads return data one cycle after the read strobe.

Top module: `irqgrp_top`

## Requirements
- R1: A one-cycle pulse on source input bit i sets status bit i at that clock edge, and a later read of the status register (offset 0) returns it set.
- R2: A write to the status register clears every bit whose byte lane is enabled and whose write data bit is 0. Bits written with 1 keep their previous value.
- R3: No software write can set a status bit. Only a source pulse sets one.
- R4: Status bits are captured regardless of the enable bits. A masked source sets its status bit but does not raise the group request.
- R5: The enable register (offset 1) is a plain read/write store. Byte lane k, selected by byte-enable bit k, covers data bits 8k to 8k+7. Lanes that are not enabled keep their old contents. A 1 in an enable bit admits that source and a 0 blocks it.
- R6: The group request output is a registered level. It is high in the cycle after any bit of (status AND enable) is set, and low in the cycle after none is set.
- R7: When a source pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: Reset clears all status and enable bits, drives the group request low and drives read data to zero.
- R9: Read data is registered and appears in the cycle after the read strobe. Offset 0 returns status, offset 1 returns the enable bits, and any other offset returns zero. Bit positions at or above the number of sources read as zero. In cycles that follow no read strobe, read data is zero.
- R10: A status write with a byte lane disabled leaves every status bit in that lane unchanged, whatever the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| src_i | input | N_SRC | Per-source event pulses, one cycle wide, synchronous to clk_i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register word offset: 0 status, 1 enable |
| reg_wdata_i | input | DATA_W | Write data |
| reg_be_i | input | DATA_W/8 | Byte-lane enables for writes |
| reg_rdata_o | output | DATA_W | Read data, valid in the cycle after reg_rd_i |
| grp_irq_o | output | 1 | Group interrupt request to the interrupt controller |

## Verification
The bench builds the block with twelve sources on a sixteen-bit register port. This puts sources in two byte lanes, so the per-lane write qualification on both registers is exercised, and it leaves four unused upper bits whose zero read-back can be checked. It also covers sources that sit in different lanes and are cleared independently. Directed sequences cover masked capture, write-one immunity, a clear colliding with a set, lane-disabled writes and the one-cycle lag of the group request. A randomized phase then mixes pulses, writes and reads against the reference model.

// File: rtl/irqgrp_pkg.sv
package irqgrp_pkg;

  // Register word offsets decoded by the block
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_ENABLE = 1;

  // Which register a read strobe selects
  typedef enum logic [1:0] {
    RSEL_NONE   = 2'd0,
    RSEL_STATUS = 2'd1,
    RSEL_ENABLE = 2'd2
  } rd_sel_e;

endpackage

// File: rtl/irqgrp_regdec.sv
module irqgrp_regdec
  import irqgrp_pkg::*;
#(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              wr_status_o,
  output logic              wr_enable_o,
  output logic [N_SRC-1:0]  bit_we_o,
  output rd_sel_e           rd_sel_o
);

  logic hit_status;
  logic hit_enable;

  assign hit_status  = (addr_i == ADDR_W'(OFS_STATUS));
  assign hit_enable  = (addr_i == ADDR_W'(OFS_ENABLE));
  assign wr_status_o = wr_i & hit_status;
  assign wr_enable_o = wr_i & hit_enable;

  // Each source bit inherits the enable of the byte lane it lives in
  for (genvar g = 0; g < N_SRC; g++) begin : g_lane
    assign bit_we_o[g] = be_i[g / 8];
  end

  always_comb begin
    rd_sel_o = RSEL_NONE;
    if (rd_i) begin
      if (hit_status)      rd_sel_o = RSEL_STATUS;
      else if (hit_enable) rd_sel_o = RSEL_ENABLE;
    end
  end

endmodule

// File: rtl/irqgrp_status_bank.sv
module irqgrp_status_bank #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] bit_we_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] status_o
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_cell
    logic clr;
    logic st_q;

    // Clear only on a lane-enabled write of zero
    assign clr = wr_i & bit_we_i[g] & ~wdata_i[g];

    always_ff @(posedge clk_i) begin
      if (!rst_ni)        st_q <= 1'b0;
      else if (src_i[g])  st_q <= 1'b1;   // hardware set has priority
      else if (clr)       st_q <= 1'b0;
    end

    assign status_o[g] = st_q;
  end

endmodule

// File: rtl/irqgrp_enable_bank.sv
module irqgrp_enable_bank #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] bit_we_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] enable_o
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_cell
    logic en_q;

    always_ff @(posedge clk_i) begin
      if (!rst_ni)                 en_q <= 1'b0;
      else if (wr_i && bit_we_i[g]) en_q <= wdata_i[g];
    end

    assign enable_o[g] = en_q;
  end

endmodule

// File: rtl/irqgrp_outreg.sv
module irqgrp_outreg
  import irqgrp_pkg::*;
#(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  status_i,
  input  logic [N_SRC-1:0]  enable_i,
  input  rd_sel_e           rd_sel_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              any_pending;
  logic [DATA_W-1:0] rd_mux;

  assign any_pending = |(status_i & enable_i);

  always_comb begin
    rd_mux = '0;
    unique case (rd_sel_i)
      RSEL_STATUS: rd_mux[N_SRC-1:0] = status_i;
      RSEL_ENABLE: rd_mux[N_SRC-1:0] = enable_i;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      irq_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      irq_o   <= any_pending;
      rdata_o <= rd_mux;
    end
  end

endmodule

// File: rtl/irqgrp_top.sv
module irqgrp_top
  import irqgrp_pkg::*;
#(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [BE_W-1:0]   reg_be_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              grp_irq_o
);

  logic             wr_status;
  logic             wr_enable;
  logic [N_SRC-1:0] bit_we;
  rd_sel_e          rd_sel;
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] enable_q;
  logic [N_SRC-1:0] wbits;

  assign wbits = reg_wdata_i[N_SRC-1:0];

  irqgrp_regdec #(
    .N_SRC (N_SRC),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_dec (
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .be_i       (reg_be_i),
    .wr_status_o(wr_status),
    .wr_enable_o(wr_enable),
    .bit_we_o   (bit_we),
    .rd_sel_o   (rd_sel)
  );

  irqgrp_status_bank #(.N_SRC(N_SRC)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_i),
    .wr_i    (wr_status),
    .bit_we_i(bit_we),
    .wdata_i (wbits),
    .status_o(status_q)
  );

  irqgrp_enable_bank #(.N_SRC(N_SRC)) u_enable (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_enable),
    .bit_we_i(bit_we),
    .wdata_i (wbits),
    .enable_o(enable_q)
  );

  irqgrp_outreg #(
    .N_SRC (N_SRC),
    .DATA_W(DATA_W)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .status_i(status_q),
    .enable_i(enable_q),
    .rd_sel_i(rd_sel),
    .irq_o   (grp_irq_o),
    .rdata_o (reg_rdata_o)
  );

endmodule

// File: rtl/irqgrp_chk.sv
module irqgrp_chk #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  src_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              grp_irq_o,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  enable_q
);

  // R6: any enabled pending status raises the request one cycle later
  a_r6_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_q & enable_q)) |=> grp_irq_o);

  // R6: no enabled pending status drops the request one cycle later
  a_r6_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(status_q & enable_q)) |=> !grp_irq_o);

  // R7: a source pulse always leaves its status bit set
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((status_q & $past(src_i)) == $past(src_i)));

  // R3: a status bit only rises where a source pulsed
  a_r3_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~$past(status_q) & ~$past(src_i)) == '0));

  // R5: enable bits change only through a write at the enable offset
  a_r5_enable_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == ADDR_W'(1)) |=> $stable(enable_q));

  // R9: read data is zero after a cycle with no read strobe
  a_r9_idle_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> (reg_rdata_o == '0));

endmodule

bind irqgrp_top irqgrp_chk #(
  .N_SRC (N_SRC),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_i      (src_i),
  .reg_wr_i   (reg_wr_i),
  .reg_rd_i   (reg_rd_i),
  .reg_addr_i (reg_addr_i),
  .reg_rdata_o(reg_rdata_o),
  .grp_irq_o  (grp_irq_o),
  .status_q   (status_q),
  .enable_q   (enable_q)
);

// File: tb/tb_irqgrp_top.sv
`timescale 1ns/1ps
module tb_irqgrp_top;

  localparam int N  = 12;
  localparam int DW = 16;
  localparam int AW = 2;
  localparam int BW = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src;
  logic          wr, rd;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [BW-1:0] be;
  logic [DW-1:0] rdata;
  logic          irq;

  always #5 clk = ~clk;

  irqgrp_top #(.N_SRC(N), .DATA_W(DW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_be_i(be),
    .reg_rdata_o(rdata), .grp_irq_o(irq)
  );

  // Reference model state
  int unsigned m_stat, m_en, m_rdata;
  bit          m_irq;
  int          n_vec  = 0;
  int          n_fail = 0;
  bit          done   = 0;

  task automatic check(string tag, int unsigned act, int unsigned exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: advance the model from the current inputs, then compare
  task automatic step();
    int unsigned nstat, nen, nrd, lane_mask, full;
    bit nirq;
    full = (1 << N) - 1;
    lane_mask = 0;
    for (int b = 0; b < N; b++) if (be[b/8]) lane_mask |= (1 << b);
    nirq  = ((m_stat & m_en) != 0);
    nrd   = 0;
    if (rd) begin
      if (addr == 0)      nrd = m_stat;
      else if (addr == 1) nrd = m_en;
    end
    nstat = m_stat;
    nen   = m_en;
    if (wr && addr == 0) nstat = nstat & ~(lane_mask & ~int'(wdata));
    if (wr && addr == 1) nen = (nen & ~lane_mask) | (int'(wdata) & lane_mask);
    nstat = (nstat | int'(src)) & full;
    @(posedge clk);
    #1;
    m_stat = nstat; m_en = nen & full; m_rdata = nrd; m_irq = nirq;
    @(negedge clk);
    check("R6 group request", int'(irq), int'(m_irq));
    check("R9 read data", int'(rdata), m_rdata);
  endtask

  task automatic idle();
    src = '0; wr = 0; rd = 0; addr = '0; wdata = '0; be = '0;
  endtask

  task automatic do_wr(input int a, input int d, input int e);
    addr = AW'(a); wdata = DW'(d); be = BW'(e); wr = 1;
    step();
    idle();
  endtask

  task automatic do_rd(input int a, output int unsigned v);
    addr = AW'(a); rd = 1;
    step();
    v = rdata;
    idle();
  endtask

  task automatic do_pulse(input int bits);
    src = N'(bits);
    step();
    idle();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned v;
    idle();
    rst_n = 0;
    m_stat = 0; m_en = 0; m_rdata = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    check("R8 reset irq", int'(irq), 0);
    check("R8 reset rdata", int'(rdata), 0);
    rst_n = 1;

    do_rd(0, v); check("R8 status after reset", v, 0);
    do_rd(1, v); check("R8 enable after reset", v, 0);

    // Masked source still captured
    do_pulse(12'h008);
    step();
    check("R4 masked source no request", int'(irq), 0);
    do_rd(0, v); check("R1 R4 status captured", v, 32'h008);

    // Lane-qualified enable write
    do_wr(1, 16'hFFFF, 2'b01);
    do_rd(1, v); check("R5 enable lane 0 only", v, 32'h0FF);
    check("R6 request after enable", int'(irq), 1);

    // Writing ones never changes status
    do_wr(0, 16'hFFFF, 2'b11);
    do_rd(0, v); check("R2 R3 write of ones", v, 32'h008);

    // Lane-disabled clear has no effect
    do_pulse(12'h202);
    do_wr(0, 16'hFFFD, 2'b10);
    do_rd(0, v); check("R10 disabled lane untouched", v, 32'h20A);
    do_wr(0, 16'hFFF7, 2'b11);
    do_rd(0, v); check("R2 clear serviced bit only", v, 32'h202);

    // Same-cycle set and clear
    src = 12'h002; wr = 1; addr = 0; wdata = 16'h0000; be = 2'b11;
    step();
    idle();
    do_rd(0, v); check("R7 set beats clear", v, 32'h002);

    // Request drops one cycle after last clear
    do_wr(0, 16'h0000, 2'b11);
    check("R6 request held on clear edge", int'(irq), 1);
    step();
    check("R6 request dropped", int'(irq), 0);

    // Unmapped offset and upper bits
    do_wr(1, 16'hFFFF, 2'b11);
    do_rd(1, v); check("R9 upper bits read zero", v, 32'hFFF);
    do_rd(2, v); check("R9 unmapped offset", v, 0);
    do_rd(3, v); check("R9 unmapped offset 3", v, 0);

    // Masking a pending source drops the request
    do_pulse(12'h800);
    step();
    check("R6 high-lane source request", int'(irq), 1);
    do_wr(1, 16'h0000, 2'b10);
    step();
    check("R6 masked off drops request", int'(irq), 0);
    do_rd(0, v); check("R4 status kept while masked", v, 32'h800);

    // Randomized mix against the model
    for (int k = 0; k < 2000; k++) begin
      src   = (($urandom % 3) == 0) ? N'($urandom) : '0;
      wr    = (($urandom % 4) == 0);
      rd    = (($urandom % 2) == 0);
      addr  = AW'($urandom);
      wdata = DW'($urandom);
      be    = BW'($urandom);
      step();
    end
    idle();
    step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule